// File: doc/BRIEF.md
# Descriptor-Chained Memory-to-Stream DMA Engine

This block is the transmit-direction engine of a DMA channel. Software places a linked list of data descriptors in memory and hands the engine a pointer to the first one. The engine fetches each descriptor over a simple request/valid read port. It then reads the buffer that the descriptor names, one byte at a time from the start address up to (not including) the end address, and presents each byte on a ready/valid byte stream to the attached client. When a buffer is exhausted, the engine acts on the descriptor's flags. It can pulse an end-of-packet marker, raise a pending interrupt and stop at end of list; when the end-of-list flag is clear, it follows the next pointer instead.

A stopped chain can be resumed in place. Software clears the end-of-list flag in the last descriptor in memory, links a new descriptor behind it and issues a continue request. The engine re-reads the current descriptor. If the flag is now clear, it follows the fresh next pointer and carries on streaming. If no client is attached, bytes are still consumed from memory but are dropped, and a data-loss indication is raised.

Register decoding is outside this block. Configuration bits, the start pointer and the interrupt mask and acknowledge arrive as plain inputs.

Top module: `dma_chain_out`

## Requirements
- R1: While and right after reset, st_valid_o, mem_req_o, eop_o, irq_o, running_o, eol_o and loss_o are all low.
- R2: A start pulse is accepted only when no transfer or descriptor fetch is in progress. An accepted start clears eol_o and loss_o, sets running_o and begins fetching the descriptor at start_ptr_i. A start pulse while busy has no effect.
- R3: A descriptor is four 32-bit little-endian words read at pointer+0, +4, +8 and +12, in that order. The words hold the next pointer, the buffer start, the buffer end and the flags. Flags bit 0 is end-of-list, bit 2 is interrupt and bit 3 is end-of-packet; bit 1 is ignored by this engine. Descriptor pointers are word aligned, and every memory request address is word aligned.
- R4: For each descriptor, the bytes at addresses start .. end-1 are delivered in ascending address order. A byte at address a is taken from lane a[1:0] of the returned word (lane 0 = bits 7:0). When start >= end, no byte is delivered.
- R5: mem_req_o stays high with a stable mem_addr_o until mem_rvalid_i is seen. Only one request is outstanding at a time.
- R6: Once st_valid_o is high, it stays high with stable st_data_o until st_ready_i is high.
- R7: After the last byte of a descriptor whose end-of-packet flag is set, eop_o pulses for exactly one cycle. This also happens for a descriptor with an empty buffer.
- R8: At the end of a buffer whose interrupt flag is set, an interrupt becomes pending. irq_o equals pending AND irq_en_i. An irq_ack_i pulse clears the pending interrupt, but a new set in the same cycle wins.
- R9: At the end of a buffer whose end-of-list flag is set, eol_o goes high and the engine makes no further memory request or stream transfer until a start or accepted continue. Otherwise the engine fetches the descriptor at the next pointer.
- R10: With client_present_i low, fetched bytes are dropped and st_valid_o stays low. The position still advances and loss_o is set; loss_o stays set until the next accepted start.
- R11: A continue pulse is ignored unless the engine is idle, cfg_en_i is high, cfg_stop_i is low, running_o is high and the current descriptor has end-of-list set.
- R12: An accepted continue re-reads the current descriptor. If its end-of-list flag is now clear, the engine clears eol_o, fetches the descriptor at its next pointer and streams on. If the flag is still set, the engine returns to idle with eol_o high and moves no data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse: load the descriptor at start_ptr_i and run |
| start_ptr_i | input | AW | Byte address of the first descriptor |
| cont_i | input | 1 | Continue request pulse |
| cfg_en_i | input | 1 | Channel enable, gates continue |
| cfg_stop_i | input | 1 | Channel stop, blocks continue |
| client_present_i | input | 1 | A stream client is attached |
| mem_req_o | output | 1 | Memory read request, held until mem_rvalid_i |
| mem_addr_o | output | AW | Word-aligned byte address of the read |
| mem_rvalid_i | input | 1 | Read data valid, completes the request |
| mem_rdata_i | input | 32 | Read data word |
| st_valid_o | output | 1 | Stream byte valid |
| st_data_o | output | 8 | Stream byte |
| st_ready_i | input | 1 | Client accepts the byte |
| eop_o | output | 1 | One-cycle end-of-packet marker |
| irq_en_i | input | 1 | Interrupt mask (1 = enabled) |
| irq_ack_i | input | 1 | Interrupt acknowledge pulse |
| irq_o | output | 1 | Masked interrupt |
| running_o | output | 1 | Channel has been started |
| eol_o | output | 1 | Channel has reached end of list |
| loss_o | output | 1 | Bytes were dropped for lack of a client |

## Verification
The bench targets unaligned buffer starts and ends, an empty buffer carrying end-of-packet, and a reversed buffer (start above end). A lane or bound error there shows up as a wrong, extra or missing byte against the model's queue. It issues a start pulse in the middle of a fetch, which a design that accepts it would answer by streaming a second chain. It sends continue requests with the channel disabled or stopped, and one against a descriptor that still has end-of-list set; a design that checks the wrong conditions would issue reads or stream stale data. A resume after the flag is cleared must skip straight to the new descriptor. The bench also checks that dropped bytes with no client raise the loss flag while the interrupt and end-of-list handling go on as usual.

// File: rtl/dma_chain_out_pkg.sv
package dma_chain_out_pkg;

    localparam int WORD_W         = 32;
    localparam int NUM_DESC_WORDS = 4;
    localparam int WIDX_W         = $clog2(NUM_DESC_WORDS);

    // Flags word bit positions (R3)
    localparam int FLAG_EOL     = 0;
    localparam int FLAG_INTR    = 2;
    localparam int FLAG_OUT_EOP = 3;

    typedef struct packed {
        logic [WORD_W-1:0] next;
        logic [WORD_W-1:0] start;
        logic [WORD_W-1:0] stop;
        logic              eol;
        logic              intr;
        logic              out_eop;
    } desc_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_CHECK,
        ST_READ,
        ST_PUSH,
        ST_END
    } eng_state_t;

    function automatic logic [7:0] pick_byte(input logic [WORD_W-1:0] w,
                                             input logic [1:0] lane);
        return w[8*lane +: 8];
    endfunction

endpackage

// File: rtl/dma_chain_out_desc.sv
module dma_chain_out_desc
    import dma_chain_out_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [WIDX_W-1:0] idx_i,
    input  logic [WORD_W-1:0] word_i,
    output desc_t             desc_o
);
    // Captures the descriptor words as they arrive (R3)
    always_ff @(posedge clk) begin
        if (rst) begin
            desc_o <= '0;
        end else if (load_i) begin
            unique case (idx_i)
                WIDX_W'(0): desc_o.next  <= word_i;
                WIDX_W'(1): desc_o.start <= word_i;
                WIDX_W'(2): desc_o.stop  <= word_i;
                default: begin
                    desc_o.eol     <= word_i[FLAG_EOL];
                    desc_o.intr    <= word_i[FLAG_INTR];
                    desc_o.out_eop <= word_i[FLAG_OUT_EOP];
                end
            endcase
        end
    end
endmodule

// File: rtl/dma_chain_out_irq.sv
module dma_chain_out_irq (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic ack_i,
    input  logic en_i,
    output logic irq_o
);
    logic pend_q;

    // R8: set has priority over a same-cycle acknowledge
    always_ff @(posedge clk) begin
        if (rst) pend_q <= 1'b0;
        else     pend_q <= (pend_q & ~ack_i) | set_i;
    end

    assign irq_o = pend_q & en_i;
endmodule

// File: rtl/dma_chain_out_sbuf.sv
module dma_chain_out_sbuf (
    input  logic       clk,
    input  logic       rst,
    input  logic       load_i,
    input  logic [7:0] byte_i,
    input  logic       ready_i,
    output logic       valid_o,
    output logic [7:0] data_o,
    output logic       done_o
);
    logic       valid_q;
    logic [7:0] data_q;

    // R6: byte is held until the client takes it
    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            data_q  <= '0;
        end else if (load_i) begin
            valid_q <= 1'b1;
            data_q  <= byte_i;
        end else if (valid_q && ready_i) begin
            valid_q <= 1'b0;
        end
    end

    assign valid_o = valid_q;
    assign data_o  = data_q;
    assign done_o  = valid_q & ready_i;
endmodule

// File: rtl/dma_chain_out.sv
module dma_chain_out
    import dma_chain_out_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [AW-1:0]     start_ptr_i,
    input  logic              cont_i,
    input  logic              cfg_en_i,
    input  logic              cfg_stop_i,
    input  logic              client_present_i,
    output logic              mem_req_o,
    output logic [AW-1:0]     mem_addr_o,
    input  logic              mem_rvalid_i,
    input  logic [WORD_W-1:0] mem_rdata_i,
    output logic              st_valid_o,
    output logic [7:0]        st_data_o,
    input  logic              st_ready_i,
    output logic              eop_o,
    input  logic              irq_en_i,
    input  logic              irq_ack_i,
    output logic              irq_o,
    output logic              running_o,
    output logic              eol_o,
    output logic              loss_o
);
    localparam logic [WIDX_W-1:0] LAST_WORD = WIDX_W'(NUM_DESC_WORDS - 1);

    eng_state_t        state_q;
    logic [AW-1:0]     dptr_q;
    logic [AW-1:0]     pos_q;
    logic [WIDX_W-1:0] widx_q;
    logic              reread_q;
    logic              eol_q;
    logic              run_q;
    logic              loss_q;

    desc_t             desc;
    logic              desc_load;
    logic              byte_load;
    logic              push_done;
    logic              cont_ok;
    logic [AW-1:0]     fetch_addr;
    logic [AW-1:0]     read_addr;

    // R11: conditions under which a continue is taken
    assign cont_ok = (state_q == ST_IDLE) && cont_i && cfg_en_i && !cfg_stop_i
                     && run_q && desc.eol;

    assign desc_load  = (state_q == ST_FETCH) && mem_rvalid_i;
    assign byte_load  = (state_q == ST_READ) && mem_rvalid_i && client_present_i;
    assign fetch_addr = dptr_q + AW'({widx_q, 2'b00});
    assign read_addr  = {pos_q[AW-1:2], 2'b00};

    assign mem_req_o  = (state_q == ST_FETCH) || (state_q == ST_READ);
    assign mem_addr_o = (state_q == ST_FETCH) ? fetch_addr : read_addr;
    assign eop_o      = (state_q == ST_END) && desc.out_eop;   // R7
    assign running_o  = run_q;
    assign eol_o      = eol_q;
    assign loss_o     = loss_q;

    dma_chain_out_desc u_desc (
        .clk    (clk),
        .rst    (rst),
        .load_i (desc_load),
        .idx_i  (widx_q),
        .word_i (mem_rdata_i),
        .desc_o (desc)
    );

    dma_chain_out_sbuf u_sbuf (
        .clk     (clk),
        .rst     (rst),
        .load_i  (byte_load),
        .byte_i  (pick_byte(mem_rdata_i, pos_q[1:0])),
        .ready_i (st_ready_i),
        .valid_o (st_valid_o),
        .data_o  (st_data_o),
        .done_o  (push_done)
    );

    dma_chain_out_irq u_irq (
        .clk   (clk),
        .rst   (rst),
        .set_i ((state_q == ST_END) && desc.intr),
        .ack_i (irq_ack_i),
        .en_i  (irq_en_i),
        .irq_o (irq_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            dptr_q   <= '0;
            pos_q    <= '0;
            widx_q   <= '0;
            reread_q <= 1'b0;
            eol_q    <= 1'b0;
            run_q    <= 1'b0;
            loss_q   <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin                 // R2
                        dptr_q   <= start_ptr_i;
                        eol_q    <= 1'b0;
                        run_q    <= 1'b1;
                        loss_q   <= 1'b0;
                        reread_q <= 1'b0;
                        widx_q   <= '0;
                        state_q  <= ST_FETCH;
                    end else if (cont_ok) begin        // R12: re-read current
                        reread_q <= 1'b1;
                        widx_q   <= '0;
                        state_q  <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    if (mem_rvalid_i) begin
                        widx_q <= widx_q + 1'b1;
                        if (widx_q == LAST_WORD) begin
                            if (reread_q) begin
                                reread_q <= 1'b0;
                                if (!mem_rdata_i[FLAG_EOL] && eol_q) begin
                                    dptr_q <= desc.next[AW-1:0];
                                    eol_q  <= 1'b0;
                                    widx_q <= '0;
                                end else begin
                                    state_q <= ST_IDLE;
                                end
                            end else begin
                                pos_q   <= desc.start[AW-1:0];
                                state_q <= ST_CHECK;
                            end
                        end
                    end
                end
                ST_CHECK: begin
                    if (pos_q >= desc.stop[AW-1:0]) state_q <= ST_END;   // R4
                    else                            state_q <= ST_READ;
                end
                ST_READ: begin
                    if (mem_rvalid_i) begin
                        if (client_present_i) begin
                            state_q <= ST_PUSH;
                        end else begin                 // R10
                            loss_q  <= 1'b1;
                            pos_q   <= pos_q + 1'b1;
                            state_q <= ST_CHECK;
                        end
                    end
                end
                ST_PUSH: begin
                    if (push_done) begin
                        pos_q   <= pos_q + 1'b1;
                        state_q <= ST_CHECK;
                    end
                end
                ST_END: begin
                    if (desc.eol) begin                // R9
                        eol_q   <= 1'b1;
                        state_q <= ST_IDLE;
                    end else begin
                        dptr_q  <= desc.next[AW-1:0];
                        widx_q  <= '0;
                        state_q <= ST_FETCH;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dma_chain_out_chk.sv
module dma_chain_out_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          mem_req_o,
    input logic [AW-1:0] mem_addr_o,
    input logic          mem_rvalid_i,
    input logic          st_valid_o,
    input logic [7:0]    st_data_o,
    input logic          st_ready_i,
    input logic          eop_o,
    input logic          irq_en_i,
    input logic          irq_o,
    input logic          eol_o,
    input logic          client_present_i
);
    assert_req_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (mem_req_o && !mem_rvalid_i) |=> (mem_req_o && $stable(mem_addr_o)));

    assert_word_aligned_R3: assert property (@(posedge clk) disable iff (rst)
        mem_req_o |-> (mem_addr_o[1:0] == 2'b00));

    assert_stream_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (st_valid_o && !st_ready_i) |=> (st_valid_o && $stable(st_data_o)));

    assert_no_client_R10: assert property (@(posedge clk) disable iff (rst)
        (!client_present_i && mem_rvalid_i && !st_valid_o) |=> !st_valid_o);

    assert_eol_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        eol_o |-> !st_valid_o);

    assert_eop_single_R7: assert property (@(posedge clk) disable iff (rst)
        eop_o |=> !eop_o);

    assert_irq_mask_R8: assert property (@(posedge clk) disable iff (rst)
        !irq_en_i |-> !irq_o);
endmodule

bind dma_chain_out dma_chain_out_chk #(.AW(AW)) u_chk (
    .clk              (clk),
    .rst              (rst),
    .mem_req_o        (mem_req_o),
    .mem_addr_o       (mem_addr_o),
    .mem_rvalid_i     (mem_rvalid_i),
    .st_valid_o       (st_valid_o),
    .st_data_o        (st_data_o),
    .st_ready_i       (st_ready_i),
    .eop_o            (eop_o),
    .irq_en_i         (irq_en_i),
    .irq_o            (irq_o),
    .eol_o            (eol_o),
    .client_present_i (client_present_i)
);

// File: tb/dma_chain_out_tb.sv
module dma_chain_out_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW         = 32;
    localparam int EOP_TOKEN  = 256;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic [AW-1:0] start_ptr_i = '0;
    logic          cont_i = 1'b0;
    logic          cfg_en_i = 1'b1;
    logic          cfg_stop_i = 1'b0;
    logic          client_present_i = 1'b1;
    logic          mem_req_o;
    logic [AW-1:0] mem_addr_o;
    logic          mem_rvalid_i = 1'b0;
    logic [31:0]   mem_rdata_i = '0;
    logic          st_valid_o;
    logic [7:0]    st_data_o;
    logic          st_ready_i = 1'b0;
    logic          eop_o;
    logic          irq_en_i = 1'b1;
    logic          irq_ack_i = 1'b0;
    logic          irq_o;
    logic          running_o;
    logic          eol_o;
    logic          loss_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_chain_out #(.AW(AW)) u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .start_ptr_i(start_ptr_i),
        .cont_i(cont_i), .cfg_en_i(cfg_en_i), .cfg_stop_i(cfg_stop_i),
        .client_present_i(client_present_i), .mem_req_o(mem_req_o),
        .mem_addr_o(mem_addr_o), .mem_rvalid_i(mem_rvalid_i),
        .mem_rdata_i(mem_rdata_i), .st_valid_o(st_valid_o),
        .st_data_o(st_data_o), .st_ready_i(st_ready_i), .eop_o(eop_o),
        .irq_en_i(irq_en_i), .irq_ack_i(irq_ack_i), .irq_o(irq_o),
        .running_o(running_o), .eol_o(eol_o), .loss_o(loss_o)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures",
                     n_checks, n_fail);
            $finish;
        end
    endtask

    // ---------------- memory model (little-endian bytes) ----------------
    logic [7:0] mem [0:1023];
    bit         busy = 1'b0;
    int         wt = 0;
    logic [AW-1:0] aaddr = '0;

    task automatic put_word(input int a, input logic [31:0] v);
        for (int k = 0; k < 4; k++) mem[a+k] = v[8*k +: 8];
    endtask

    function automatic logic [31:0] get_word(input logic [AW-1:0] a);
        int b;
        b = int'(a[9:0]);
        return {mem[b+3], mem[b+2], mem[b+1], mem[b]};
    endfunction

    always @(negedge clk) begin
        mem_rvalid_i <= 1'b0;
        if (!rst) begin
            if (busy) begin
                // R5: request must be held with the same address
                if (!mem_req_o || mem_addr_o != aaddr)
                    chk(1'b0, "R5", "request dropped or moved", int'(mem_addr_o), int'(aaddr));
                if (wt == 0) begin
                    mem_rvalid_i <= 1'b1;
                    mem_rdata_i  <= get_word(aaddr);
                    busy         <= 1'b0;
                end else begin
                    wt <= wt - 1;
                end
            end else if (mem_req_o && !mem_rvalid_i) begin
                busy  <= 1'b1;
                wt    <= $urandom_range(0, 2);
                aaddr <= mem_addr_o;
            end
        end
    end

    // ---------------- client ready pattern ----------------
    always @(posedge clk) begin
        #1;
        st_ready_i = ($urandom_range(0, 3) != 0);
    end

    // ---------------- reference queue and per-cycle monitor ----------------
    int   exp_q[$];
    int   req_cycles = 0;
    bit   saw_eol_low = 1'b0;
    bit   hold_prev = 1'b0;
    logic [7:0] hold_data = '0;

    task automatic expect_bytes(input int a, input int b);
        for (int i = a; i < b; i++) exp_q.push_back(int'(mem[i]));
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            req_cycles += int'(mem_req_o);
            if (!eol_o) saw_eol_low = 1'b1;
            if (hold_prev)
                chk(st_valid_o && st_data_o == hold_data, "R6", "byte held until ready",
                    int'(st_data_o), int'(hold_data));
            if (st_valid_o && !client_present_i)
                chk(1'b0, "R10", "valid without client", 1, 0);
            if (st_valid_o && st_ready_i) begin
                if (exp_q.size() == 0)
                    chk(1'b0, "R4", "unexpected byte", int'(st_data_o), -1);
                else begin
                    chk(exp_q[0] == int'(st_data_o), "R4", "byte value/order (R3 layout)",
                        int'(st_data_o), exp_q[0]);
                    void'(exp_q.pop_front());
                end
            end
            if (eop_o) begin
                if (exp_q.size() == 0)
                    chk(1'b0, "R7", "unexpected end-of-packet", EOP_TOKEN, -1);
                else begin
                    chk(exp_q[0] == EOP_TOKEN, "R7", "end-of-packet position",
                        EOP_TOKEN, exp_q[0]);
                    void'(exp_q.pop_front());
                end
            end
            hold_prev = st_valid_o && !st_ready_i;
            hold_data = st_data_o;
        end
    end

    // ---------------- watchdog ----------------
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !finished) begin
            chk(1'b0, "WD", "watchdog expired", cyc, 100000);
            finish_up();
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic pulse_start(input int ptr);
        @(posedge clk); #1;
        start_i = 1'b1; start_ptr_i = AW'(ptr);
        @(posedge clk); #1;
        start_i = 1'b0;
    endtask

    task automatic pulse_cont();
        @(posedge clk); #1;
        cont_i = 1'b1;
        @(posedge clk); #1;
        cont_i = 1'b0;
    endtask

    task automatic wait_idle(input string req);
        int quiet = 0;
        int t = 0;
        while (quiet < 8 && t < 5000) begin
            @(negedge clk);
            t++;
            if (!mem_req_o && !st_valid_o) quiet++;
            else quiet = 0;
        end
        chk(quiet >= 8, req, "engine settles", quiet, 8);
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    int rc;

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 8'((i * 7 + 3) & 255);
        // D0: 5 bytes, unaligned start
        put_word(32'h00, 32'h10);  put_word(32'h04, 32'h101); put_word(32'h08, 32'h106); put_word(32'h0C, 32'h0);
        // D1: 3 bytes, intr + end-of-packet
        put_word(32'h10, 32'h20);  put_word(32'h14, 32'h10A); put_word(32'h18, 32'h10D); put_word(32'h1C, 32'hC);
        // D2: empty buffer, end-of-list + end-of-packet
        put_word(32'h20, 32'h30);  put_word(32'h24, 32'h110); put_word(32'h28, 32'h110); put_word(32'h2C, 32'h9);
        // D3: 2 bytes, end-of-list
        put_word(32'h30, 32'h0);   put_word(32'h34, 32'h120); put_word(32'h38, 32'h122); put_word(32'h3C, 32'h1);
        // D4: 3 bytes, end-of-list + intr
        put_word(32'h40, 32'h0);   put_word(32'h44, 32'h130); put_word(32'h48, 32'h133); put_word(32'h4C, 32'h5);
        // D5: start above end, end-of-list (bit 1 set too, ignored)
        put_word(32'h50, 32'h0);   put_word(32'h54, 32'h210); put_word(32'h58, 32'h208); put_word(32'h5C, 32'h3);

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(!st_valid_o && !mem_req_o && !eop_o, "R1", "outputs quiet in reset", int'(st_valid_o), 0);
        @(posedge clk); #1; rst = 1'b0;
        @(negedge clk);
        chk(!irq_o && !running_o && !eol_o && !loss_o, "R1", "status low after reset",
            int'({irq_o, running_o, eol_o, loss_o}), 0);
        chk(!mem_req_o && !st_valid_o, "R1", "no activity after reset", int'(mem_req_o), 0);

        // R11: continue ignored before any start
        rc = req_cycles;
        pulse_cont();
        idle_cycles(10);
        chk(req_cycles == rc, "R11", "continue before start ignored", req_cycles, rc);

        // Chain D0 -> D1 -> D2, with a start pulse during the fetch
        expect_bytes(32'h101, 32'h106);
        expect_bytes(32'h10A, 32'h10D);
        exp_q.push_back(EOP_TOKEN);
        exp_q.push_back(EOP_TOKEN);
        pulse_start(32'h00);
        chk(running_o && !eol_o, "R2", "start sets running, clears eol", int'({running_o, eol_o}), 2);
        idle_cycles(2);
        pulse_start(32'h40);   // R2: must be ignored while fetching
        wait_idle("R9");
        chk(exp_q.size() == 0, "R2", "only the first chain delivered", exp_q.size(), 0);
        chk(eol_o == 1'b1, "R9", "end of list reached", int'(eol_o), 1);
        chk(irq_o == 1'b1, "R8", "interrupt from flagged descriptor", int'(irq_o), 1);
        rc = req_cycles;
        idle_cycles(20);
        chk(req_cycles == rc, "R9", "no requests after end of list", req_cycles, rc);

        // R8: mask and acknowledge
        @(posedge clk); #1; irq_en_i = 1'b0;
        @(negedge clk);
        chk(irq_o == 1'b0, "R8", "masked interrupt low", int'(irq_o), 0);
        @(posedge clk); #1; irq_en_i = 1'b1;
        @(negedge clk);
        chk(irq_o == 1'b1, "R8", "pending survives mask", int'(irq_o), 1);
        @(posedge clk); #1; irq_ack_i = 1'b1;
        @(posedge clk); #1; irq_ack_i = 1'b0;
        @(negedge clk);
        chk(irq_o == 1'b0, "R8", "acknowledge clears", int'(irq_o), 0);

        // R11: continue with channel disabled, then stopped
        rc = req_cycles;
        cfg_en_i = 1'b0;
        pulse_cont();
        idle_cycles(10);
        chk(req_cycles == rc, "R11", "continue ignored when disabled", req_cycles, rc);
        cfg_en_i = 1'b1; cfg_stop_i = 1'b1;
        pulse_cont();
        idle_cycles(10);
        chk(req_cycles == rc, "R11", "continue ignored when stopped", req_cycles, rc);
        cfg_stop_i = 1'b0;

        // R12: continue while descriptor still has end-of-list
        pulse_cont();
        wait_idle("R12");
        chk(req_cycles >= rc + 4, "R12", "descriptor re-read", req_cycles - rc, 4);
        chk(eol_o == 1'b1, "R12", "still at end of list", int'(eol_o), 1);
        chk(exp_q.size() == 0, "R12", "no data moved", exp_q.size(), 0);

        // R12: clear end-of-list in D2, resume into D3
        put_word(32'h2C, 32'h8);
        expect_bytes(32'h120, 32'h122);
        saw_eol_low = 1'b0;
        pulse_cont();
        wait_idle("R12");
        chk(saw_eol_low, "R12", "eol cleared on resume", int'(saw_eol_low), 1);
        chk(exp_q.size() == 0, "R12", "resumed chain delivered", exp_q.size(), 0);
        chk(eol_o == 1'b1, "R9", "stops at D3", int'(eol_o), 1);
        chk(irq_o == 1'b0, "R8", "no interrupt without flag", int'(irq_o), 0);

        // R10: no client, bytes dropped
        client_present_i = 1'b0;
        pulse_start(32'h40);
        wait_idle("R10");
        chk(loss_o == 1'b1, "R10", "loss flagged", int'(loss_o), 1);
        chk(eol_o == 1'b1, "R10", "chain still finishes", int'(eol_o), 1);
        chk(irq_o == 1'b1, "R8", "interrupt still raised with no client", int'(irq_o), 1);

        // R4: start above end gives no bytes; R2: start clears loss
        client_present_i = 1'b1;
        pulse_start(32'h50);
        chk(loss_o == 1'b0, "R2", "start clears loss", int'(loss_o), 0);
        wait_idle("R4");
        chk(exp_q.size() == 0, "R4", "reversed buffer empty", exp_q.size(), 0);
        chk(eol_o == 1'b1, "R9", "reversed descriptor ends list", int'(eol_o), 1);

        idle_cycles(5);
        finish_up();
    end
endmodule